// File: doc/BRIEF.md
# Four-by-four unsigned column-compression multiplier

This block multiplies two 4-bit unsigned operands into an 8-bit product. Each operand bit pair is ANDed to form sixteen partial-product bits. Bit `op_a[i] & op_b[j]` is placed in the column of weight 2^(i+j). The columns are then compressed in two stages, using only half adders and full adders, until every column holds at most two wires. Each stage adds only as many adders as it needs to bring the columns down to the next target in the height sequence 2, 3, 4, 6, …. The two remaining rows go to a ripple-carry adder, which produces all eight product bits.

A parameter selects whether the product leaves the block straight from the final adder or through a register with asynchronous active-low reset. In the registered build, which is the default, the product appears one clock after the operands are sampled. A column that already meets its stage target passes through that stage without an adder. Each full adder is two half adders whose carries are ORed together.

Top module: `dadda_mul4`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `product` equals `op_a * op_b` as an 8-bit unsigned value.
- R2: With `REG_OUT` = 1, `product` shows the result for the operands sampled at the previous rising edge of `clk`. Operand changes between edges do not reach `product` until the next rising edge.
- R3: While `rst_n` is low, `product` is cleared to 0. The clear is asynchronous, and `product` stays 0 through the following edge.
- R4: The compression tree delivers two rows, 7 bits each, whose unsigned sum equals `op_a * op_b`. Row bit k carries weight 2^k.
- R5: If either operand is 0, `product` is 0.
- R6: The largest operands, 15 × 15, give 225 (0xE1) with no bit lost.
- R7: While both operands stay unchanged across edges, `product` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| product | output | 8 | Unsigned product |

## Verification
The bench builds the block with its defaults: 4-bit operands and the registered output. Because the operand space has only 256 pairs, every pair can be applied and compared with a behavioural reference that is delayed one cycle through a queue. The zero rows and columns and the 15 × 15 corner are therefore covered as well. The registered build also makes it possible to observe the one-cycle latency, the hold under steady operands and the asynchronous clear in the middle of a run.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

   localparam int DEF_OP_W = 4;

   // Largest member of the sequence 2,3,4,6,9,... that is strictly below h.
   function automatic int dadda_below(input int h);
      int d;
      d = 2;
      while ((d * 3) / 2 < h) d = (d * 3) / 2;
      return d;
   endfunction

endpackage

// File: rtl/mul_half_adder.sv
module mul_half_adder (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   assign s = x ^ y;
   assign c = x & y;
endmodule

// File: rtl/mul_full_adder.sv
module mul_full_adder (
   input  logic x,
   input  logic y,
   input  logic z,
   output logic s,
   output logic c
);
   logic s_lo, c_lo, c_hi;

   mul_half_adder u_ha_lo (.x(x),    .y(y), .s(s_lo), .c(c_lo));
   mul_half_adder u_ha_hi (.x(s_lo), .y(z), .s(s),    .c(c_hi));

   assign c = c_lo | c_hi;
endmodule

// File: rtl/mul_ripple_adder.sv
module mul_ripple_adder #(
   parameter int W = 7
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] carry;

   if (W < 1) begin : g_bad_w
      $error("mul_ripple_adder: W must be at least 1");
   end

   assign carry[0] = 1'b0;

   for (genvar k = 0; k < W; k++) begin : g_bit
      mul_full_adder u_fa (
         .x(x[k]),
         .y(y[k]),
         .z(carry[k]),
         .s(sum[k]),
         .c(carry[k+1])
      );
   end

   assign cout = carry[W];
endmodule

// File: rtl/mul_dadda_tree.sv
module mul_dadda_tree #(
   parameter int OP_W = dadda_pkg::DEF_OP_W
) (
   input  logic [OP_W-1:0]   a,
   input  logic [OP_W-1:0]   b,
   output logic [2*OP_W-2:0] row_x,
   output logic [2*OP_W-2:0] row_y
);
   localparam int MAX_H = OP_W;
   localparam int TGT_1 = dadda_pkg::dadda_below(MAX_H);
   localparam int TGT_2 = dadda_pkg::dadda_below(TGT_1);

   if (OP_W != 4) begin : g_bad_width
      $error("mul_dadda_tree: the compression network is laid out for 4-bit operands");
   end
   if (TGT_1 != 3 || TGT_2 != 2) begin : g_bad_sched
      $error("mul_dadda_tree: stage targets do not match the 3,2 schedule");
   end

   // pp[i][j] = a[i] & b[j], weight 2^(i+j)
   logic [OP_W-1:0] pp [OP_W];

   for (genvar i = 0; i < OP_W; i++) begin : g_row
      for (genvar j = 0; j < OP_W; j++) begin : g_col
         assign pp[i][j] = a[i] & b[j];
      end
   end

   // Stage 1, target height 3: column 3 has 4 wires, column 4 rises to 4
   logic st1_s3, st1_c4, st1_s4, st1_c5;

   mul_half_adder u_s1_w3 (.x(pp[0][3]), .y(pp[1][2]), .s(st1_s3), .c(st1_c4));
   mul_half_adder u_s1_w4 (.x(pp[1][3]), .y(pp[2][2]), .s(st1_s4), .c(st1_c5));

   // Stage 2, target height 2
   logic st2_s2, st2_c3, st2_s3, st2_c4, st2_s4, st2_c5, st2_s5, st2_c6;

   mul_half_adder u_s2_w2 (.x(pp[0][2]), .y(pp[1][1]), .s(st2_s2), .c(st2_c3));
   mul_full_adder u_s2_w3 (.x(st1_s3),   .y(pp[2][1]), .z(pp[3][0]), .s(st2_s3), .c(st2_c4));
   mul_full_adder u_s2_w4 (.x(st1_s4),   .y(pp[3][1]), .z(st1_c4),   .s(st2_s4), .c(st2_c5));
   mul_full_adder u_s2_w5 (.x(pp[2][3]), .y(pp[3][2]), .z(st1_c5),   .s(st2_s5), .c(st2_c6));

   // Two rows handed to the carry-propagate adder
   assign row_x = {pp[3][3], st2_s5, st2_s4, st2_s3, st2_s2, pp[0][1], pp[0][0]};
   assign row_y = {st2_c6,   st2_c5, st2_c4, st2_c3, pp[2][0], pp[1][0], 1'b0};
endmodule

// File: rtl/dadda_mul4.sv
module dadda_mul4 #(
   parameter int OP_W    = dadda_pkg::DEF_OP_W,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [2*OP_W-1:0] product
);
   localparam int PROD_W = 2 * OP_W;
   localparam int ROW_W  = PROD_W - 1;

   logic [ROW_W-1:0]  row_x, row_y;
   logic [ROW_W-1:0]  cpa_sum;
   logic              cpa_cout;
   logic [PROD_W-1:0] prod_comb;

   mul_dadda_tree #(.OP_W(OP_W)) u_tree (
      .a    (op_a),
      .b    (op_b),
      .row_x(row_x),
      .row_y(row_y)
   );

   mul_ripple_adder #(.W(ROW_W)) u_cpa (
      .x   (row_x),
      .y   (row_y),
      .sum (cpa_sum),
      .cout(cpa_cout)
   );

   assign prod_comb = {cpa_cout, cpa_sum};

   if (REG_OUT) begin : g_reg
      logic [PROD_W-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_q <= '0;
         else        prod_q <= prod_comb;
      end
      assign product = prod_q;
   end else begin : g_comb
      assign product = prod_comb;
   end
endmodule

// File: rtl/dadda_mul4_chk.sv
module dadda_mul4_chk #(
   parameter int OP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic [2*OP_W-1:0] product,
   input logic [2*OP_W-2:0] row_x,
   input logic [2*OP_W-2:0] row_y
);
   localparam int PW = 2 * OP_W;

   assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> product == PW'($past(op_a) * $past(op_b)))
      else $error("product does not match previous operands");

   assert_clear_R3: assert property (@(posedge clk)
      !rst_n |=> product == '0)
      else $error("product not cleared by reset");

   assert_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      PW'(PW'(row_x) + PW'(row_y)) == PW'(op_a * op_b))
      else $error("tree rows do not sum to the product");

   assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> product == '0)
      else $error("zero operand gave nonzero product");

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(product))
      else $error("product moved under steady operands");
endmodule

bind dadda_mul4 dadda_mul4_chk #(.OP_W(OP_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_a   (op_a),
   .op_b   (op_b),
   .product(product),
   .row_x  (row_x),
   .row_y  (row_y)
);

// File: tb/dadda_mul4_tb.sv
module dadda_mul4_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_a = '0;
   logic [3:0] op_b = '0;
   logic [7:0] product;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   dadda_mul4 u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_a   (op_a),
      .op_b   (op_b),
      .product(product)
   );

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: product=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      string tag;
      int    exp_v;
      // R3: product cleared while reset held
      repeat (2) @(negedge clk);
      check("R3 reset", int'(product), 0);
      rst_n = 1'b1;

      // R1/R4/R5/R6: all operand pairs, result one cycle later
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            if (exp_q.size() > 0) begin
               exp_v = exp_q.pop_front();
               tag = (exp_v == 0) ? "R5 zero operand" :
                     (exp_v == 225) ? "R6 max operands" : "R1/R4 product";
               check(tag, int'(product), exp_v);
            end
            op_a = 4'(a);
            op_b = 4'(b);
            exp_q.push_back(a * b);
            @(negedge clk);
         end
      end
      exp_v = exp_q.pop_front();
      check("R6 max operands", int'(product), exp_v);

      // R2: new operands not visible before the edge
      op_a = 4'd3;
      op_b = 4'd5;
      #1;
      check("R2 before edge", int'(product), 225);
      @(negedge clk);
      check("R2 after edge", int'(product), 15);

      // R7: steady operands keep the product
      repeat (2) begin
         @(negedge clk);
         check("R7 hold", int'(product), 15);
      end

      // R3: asynchronous clear mid-run
      rst_n = 1'b0;
      #1;
      check("R3 async clear", int'(product), 0);
      @(negedge clk);
      check("R3 held in reset", int'(product), 0);
      rst_n = 1'b1;
      op_a = 4'd9;
      op_b = 4'd7;
      @(negedge clk);
      check("R1 after reset", int'(product), 63);

      done = 1'b1;
      finish_run();
   end
endmodule